// File: doc/BRIEF.md
# GPIO Edge Interrupt Unit

This block combines up to 32 already-sampled general-purpose input lines into one interrupt request line. Each line has a bit in an enable mask and a bit in a polarity register. The polarity bit selects whether a rising or a falling transition counts as an event. An enabled event latches a bit in a sticky pending register, and that bit stays set until software writes it back to zero. A single global enable bit in a control register gates the request line. Turning the gate off removes the request but leaves every pending bit in place.

Software reaches the four registers through a plain synchronous register port. A write is taken on the rising clock edge when `reg_wr` is high. Read data is combinational and follows `reg_addr`. There is no stream traffic, so the port has no valid/ready handshake: a write is always accepted in the cycle it is presented, and a read never stalls.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, all four registers read zero and `irq_o` is low.
- R2: With the polarity bit of a pin at 0, a high-to-low change on that enabled pin sets its pending bit at the first clock edge that sees the new level.
- R3: With the polarity bit of a pin at 1, a low-to-high change on that enabled pin sets its pending bit at the first clock edge that sees the new level.
- R4: A transition of the opposite direction sets no pending bit, and neither do inputs held static.
- R5: A pin whose enable-mask bit is 0 never sets its pending bit.
- R6: `irq_o` is a register that holds the global enable AND the OR of all pending bits. It is high one clock after a pending bit sets, which is two edges after the input change.
- R7: Writing 0 to control bit 0 drops `irq_o` one clock after the write edge, and the pending bits keep their values. Writing it back to 1 raises the request again.
- R8: A write to the pending register (offset 2) loads the written value. Writing zeros clears pending bits, and a bit written as 0 stays clear.
- R9: If an enabled event occurs in the same cycle as a write of 0 to that pin's pending bit, the event wins and the bit reads 1.
- R10: The registers sit at word offsets 0 (enable mask), 1 (polarity), 2 (pending) and 3 (control). They read back what was written, except that the control register keeps only bit 0 and its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Sampled input lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong edge-history bit or a wrong polarity select shows up at the pending-register readback at the very next edge after the input change. It appears there as a missing bit or an extra bit for that pin alone. A stuck or dropped pending bit, or a wrong gate, shows on `irq_o` one cycle later. The bench sweeps every pin through both polarities, both mask values and both transition directions, so a mistake confined to one lane or one mode cannot hide.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned CTRL_GEN_BIT = 0;

  typedef enum logic [REG_AW-1:0] {
    OFS_MASK   = 2'd0,
    OFS_POL    = 2'd1,
    OFS_STATUS = 2'd2,
    OFS_CTRL   = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] hit_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic rise, fall;
    always_comb begin
      rise     = pin_i[g] & ~prev_q[g];
      fall     = ~pin_i[g] & prev_q[g];
      hit_o[g] = mask_i[g] & (pol_i[g] ? rise : fall);
    end
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] base;

  // Events are ORed in after the software value, so a set beats a clear.
  always_comb base = wr_i ? wdata_i : status_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= base | hit_i;
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [N-1:0]      status_i,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      pol_o,
  output logic              gen_o,
  output logic              wr_status_o,
  output logic [DW-1:0]     rdata_o
);
  always_comb wr_status_o = wr_i && (addr_i == OFS_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      pol_o  <= '0;
      gen_o  <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_MASK: mask_o <= wdata_i[N-1:0];
        OFS_POL:  pol_o  <= wdata_i[N-1:0];
        OFS_CTRL: gen_o  <= wdata_i[CTRL_GEN_BIT];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_MASK:   rdata_o[N-1:0] = mask_o;
      OFS_POL:    rdata_o[N-1:0] = pol_o;
      OFS_STATUS: rdata_o[N-1:0] = status_i;
      default:    rdata_o[CTRL_GEN_BIT] = gen_o;
    endcase
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_o
);
  logic [NPINS-1:0] mask_q, pol_q, status_q, set_vec;
  logic             ctrl_en, wr_status;

  gpio_irq_regs #(.N(NPINS), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .status_i(status_q), .mask_o(mask_q),
    .pol_o(pol_q), .gen_o(ctrl_en), .wr_status_o(wr_status),
    .rdata_o(reg_rdata)
  );

  gpio_irq_edge #(.N(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pol_i(pol_q),
    .mask_i(mask_q), .hit_o(set_vec)
  );

  gpio_irq_status #(.N(NPINS)) u_status (
    .clk(clk), .rst_n(rst_n), .hit_i(set_vec), .wr_i(wr_status),
    .wdata_i(reg_wdata[NPINS-1:0]), .status_o(status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= ctrl_en & (|status_q);
  end
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
  parameter int unsigned N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq_o,
  input logic         ctrl_en,
  input logic         wr_status,
  input logic [N-1:0] status,
  input logic [N-1:0] mask,
  input logic [N-1:0] set_vec
);
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(ctrl_en));
  p_irq_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|status));
  p_gate_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !irq_o);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_status |=> ((status & $past(status)) == $past(status)));
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_status |=> ((status & ~$past(status) & ~$past(mask)) == '0));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> ((status & $past(set_vec)) == $past(set_vec)));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.N(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .ctrl_en(ctrl_en),
  .wr_status(wr_status), .status(status_q), .mask(mask_q),
  .set_vec(set_vec)
);

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb;
  localparam int NP = 32;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, irq_o;
  logic [NP-1:0] pin_i = '0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gpio_irq_unit u_dut (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, e;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a[1:0], v); chk("R1 reg", v, 0); end
    chk("R1 irq", {31'd0, irq_o}, 0);
    rst_n = 1'b1;
    tick();

    // R10 readback
    wr(2'd0, 32'h1234_5678); rd(2'd0, v); chk("R10 mask", v, 32'h1234_5678);
    wr(2'd1, 32'hCAFE_F00D); rd(2'd1, v); chk("R10 pol", v, 32'hCAFE_F00D);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R10 ctrl", v, 32'h1);
    wr(2'd0, 0);

    // R2 R3 R4 R5 sweep: pin, polarity, mask, direction (1 = rising)
    for (int p = 0; p < NP; p++)
      for (int pol = 0; pol < 2; pol++)
        for (int m = 0; m < 2; m++)
          for (int dir = 0; dir < 2; dir++) begin
            wr(2'd0, 0);
            pin_i = dir ? '0 : '1;
            tick();
            wr(2'd2, 0);
            wr(2'd1, pol ? 32'hFFFF_FFFF : 32'h0);
            wr(2'd0, m ? (32'd1 << p) : 32'd0);
            pin_i[p] = ~pin_i[p];
            tick();
            e = (m == 1 && dir == pol) ? (32'd1 << p) : 32'd0;
            rd(2'd2, v);
            if (m == 0) chk("R5 masked", v, e);
            else if (dir != pol) chk("R4 opposite", v, e);
            else if (pol == 1) chk("R3 rise", v, e);
            else chk("R2 fall", v, e);
            tick();
            chk("R6 irq follows", {31'd0, irq_o}, {31'd0, e != 0});
          end

    // R4 static levels
    wr(2'd0, 32'hFFFF_FFFF); wr(2'd1, 32'h0000_FFFF);
    pin_i = 32'h0000_0000; tick(); wr(2'd2, 0);
    repeat (10) tick();
    rd(2'd2, v); chk("R4 static", v, 0);
    chk("R4 static irq", {31'd0, irq_o}, 0);

    // R6 timing: status at first edge, irq at second
    pin_i[3] = 1'b1;
    tick(); rd(2'd2, v); chk("R6 status", v, 32'h8);
    chk("R6 irq not yet", {31'd0, irq_o}, 0);
    tick(); chk("R6 irq up", {31'd0, irq_o}, 1);

    // R7 gate drop, status kept, re-raise
    wr(2'd3, 0);
    chk("R7 irq one cycle lag", {31'd0, irq_o}, 1);
    tick(); chk("R7 irq dropped", {31'd0, irq_o}, 0);
    rd(2'd2, v); chk("R7 status kept", v, 32'h8);
    wr(2'd3, 1); tick(); chk("R7 irq back", {31'd0, irq_o}, 1);

    // R8 direct load and clear
    wr(2'd0, 0);
    wr(2'd2, 32'hA5A5_0F0F); rd(2'd2, v); chk("R8 load", v, 32'hA5A5_0F0F);
    wr(2'd2, 32'h0000_0F0F); rd(2'd2, v); chk("R8 partial clear", v, 32'h0000_0F0F);
    wr(2'd2, 0); rd(2'd2, v); chk("R8 clear", v, 0);
    tick(); chk("R8 irq off", {31'd0, irq_o}, 0);

    // R9 event vs. clearing write in the same cycle
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd0, 32'h1);
    pin_i = '0; tick();
    wr(2'd2, 32'h0000_00F0);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0; pin_i[0] = 1'b1;
    @(posedge clk); @(negedge clk); reg_wr = 1'b0;
    rd(2'd2, v); chk("R9 set wins", v, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule